// File: doc/BRIEF.md
# DRAM Strobe Refresh Mode Decoder

This block is the control front end of a behavioural EDO DRAM model. It samples the active-low row strobe, a set of per-lane column strobes, the write enable, the output enable and the multiplexed address bus on every clock. From these it works out what kind of cycle each row-strobe-low period is. There are four kinds: a normal access, a row-strobe-only refresh, a column-before-row refresh, and a hidden refresh. Page-mode accesses, where the column strobe toggles several times while the row stays open, are part of a normal access.

The block keeps an internal refresh row counter. It drives the row select and the column address towards the array. It issues one write strobe per lane and holds a drive enable per data lane. That drive enable follows the extended-data-out rules: read data stays on the pins after the column strobe rises, and is released only when all strobes are high or when output enable is withdrawn.

The core is a five-state machine. Each state's code is also the mode reported on `mode_o`:
- IDLE = 0
- RW = 1 (normal or page access)
- ROR = 2 (row open, no column strobe yet: row-strobe-only refresh)
- CBR = 3
- HID = 4 (hidden refresh)

The transitions are:
- **open**: IDLE to ROR, when the row strobe falls with every column strobe high.
- **cbr_start**: IDLE to CBR, when the row strobe falls with some column strobe low and no lane driving.
- **hid_start**: IDLE to HID, when the row strobe falls with some column strobe low and a lane still driving.
- **col_hit**: ROR to RW, on the first falling column strobe.
- **close**: any active state to IDLE, when the row strobe is sampled high.

Top module: `dram_mode_dec`

## Requirements
- R1: After reset, `mode_o` is 0, `row_act`, `wr_en` and `dq_oe` are 0, and the refresh counter is 0, so the first refresh that uses the counter selects row 0.
- R2: When `ras_n` is sampled falling while all `cas_n` bits are high, the next cycle shows `mode_o`=2, `row_act`=1 and `row_sel` equal to `addr` at that edge, and `dq_oe` stays 0 while in that mode.
- R3: A falling `cas_n` bit while in mode 2 moves `mode_o` to 1, and `row_sel` is unchanged.
- R4: While the row is open, `col_addr` follows `addr` as long as every column strobe was high at the previous edge. The address sampled at the edge where a column strobe falls is therefore kept, and it holds while that strobe stays low.
- R5: If `we_n` is low at the edge where `cas_n[i]` falls during an open row, `wr_en[i]` is 1 for exactly the next cycle and lane i does not drive.
- R6: If `we_n` is high at that edge, lane i starts driving, and `dq_oe[i]` = drive & !`oe_n`. The drive persists after `cas_n[i]` rises and after `ras_n` rises.
- R7: A lane's drive is cleared at an edge where `ras_n` and all `cas_n` are high, or where `ras_n` falls with all `cas_n` high.
- R8: When `ras_n` falls with some `cas_n` low and no lane driving, `mode_o` becomes 3 and `row_sel` is the refresh counter. `dq_oe` and `wr_en` stay 0 whatever `we_n` and `oe_n` do.
- R9: When `ras_n` falls with some `cas_n` low and a lane still driving from a read, `mode_o` becomes 4, `row_sel` is the refresh counter, and the drive continues (still gated by `oe_n`).
- R10: The counter advances by one when a mode 3 or mode 4 cycle ends. It wraps from 2^ROW_W-1 to 0. It is not changed by mode 1 or mode 2 cycles.
- R11: `ras_n` sampled high in any active mode returns `mode_o` to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sampling clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ras_n | input | 1 | row strobe, active low |
| cas_n | input | N_LANE | per-lane column strobes, active low |
| we_n | input | 1 | write enable, active low |
| oe_n | input | 1 | output enable, active low |
| addr | input | ROW_W | multiplexed row/column address |
| mode_o | output | 3 | current cycle kind (0..4) |
| row_act | output | 1 | a row is selected |
| row_sel | output | ROW_W | selected row |
| col_addr | output | ROW_W | column address held for the array |
| wr_en | output | N_LANE | one-cycle write strobe per lane |
| dq_oe | output | N_LANE | data pin drive enable per lane |

## Verification
If the state machine picks the wrong kind of cycle, `mode_o` shows it one cycle after the row strobe falls. A wrong choice between the two counter-based refresh kinds also shows on `dq_oe` in that same cycle. A corrupted refresh counter does not show until the next counter-based refresh, where `row_sel` is off from the count the bench keeps; missing wrap-around needs a full sweep of the row space to appear. A stuck lane drive shows on `dq_oe` in the cycle after all strobes return high.

// File: rtl/dram_mode_pkg.sv
package dram_mode_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RW   = 3'd1,
        ST_ROR  = 3'd2,
        ST_CBR  = 3'd3,
        ST_HID  = 3'd4
    } dmode_e;
endpackage

// File: rtl/strobe_edges.sv
module strobe_edges #(
    parameter int N_LANE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic [N_LANE-1:0] cas_n,
    output logic              ras_fall,
    output logic [N_LANE-1:0] cas_fall,
    output logic              cas_hi_prev
);
    logic              ras_q;
    logic [N_LANE-1:0] cas_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= '1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
        end
    end

    assign ras_fall    = ras_q & ~ras_n;
    assign cas_fall    = cas_q & ~cas_n;
    assign cas_hi_prev = &cas_q;
endmodule

// File: rtl/rfsh_counter.sv
module rfsh_counter #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [ROW_W-1:0] cnt
);
    localparam logic [ROW_W-1:0] ONE = ROW_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (bump)
            cnt <= cnt + ONE;
    end

    // R10
    rc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == ROW_W'($past(cnt) + ONE)));
endmodule

// File: rtl/lane_ctrl.sv
module lane_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic open_row,
    input  logic cas_fall,
    input  logic we_n,
    input  logic oe_n,
    input  logic release_all,
    output logic wr_en,
    output logic drive,
    output logic dq_oe
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive <= 1'b0;
            wr_en <= 1'b0;
        end else begin
            wr_en <= open_row & cas_fall & ~we_n;
            if (release_all)
                drive <= 1'b0;
            else if (open_row && cas_fall)
                drive <= we_n;
        end
    end

    assign dq_oe = drive & ~oe_n;

    // R5
    wr_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !drive);
endmodule

// File: rtl/dram_mode_dec.sv
module dram_mode_dec
    import dram_mode_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int N_LANE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic [N_LANE-1:0] cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ROW_W-1:0]  addr,
    output logic [2:0]        mode_o,
    output logic              row_act,
    output logic [ROW_W-1:0]  row_sel,
    output logic [ROW_W-1:0]  col_addr,
    output logic [N_LANE-1:0] wr_en,
    output logic [N_LANE-1:0] dq_oe
);
    dmode_e             state, nxt;
    logic               ras_fall, cas_hi_prev;
    logic [N_LANE-1:0]  cas_fall, drive;
    logic [ROW_W-1:0]   cnt, row_q, col_q;
    logic               open_row, release_all, bump;

    strobe_edges #(.N_LANE(N_LANE)) u_edges (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .ras_fall(ras_fall), .cas_fall(cas_fall), .cas_hi_prev(cas_hi_prev)
    );

    assign bump = (state == ST_CBR || state == ST_HID) && ras_n;

    rfsh_counter #(.ROW_W(ROW_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .bump(bump), .cnt(cnt)
    );

    assign open_row    = (state == ST_ROR || state == ST_RW) && !ras_n;
    assign release_all = (&cas_n) && (ras_n || ras_fall);

    for (genvar i = 0; i < N_LANE; i++) begin : g_lane
        lane_ctrl u_lane (
            .clk(clk), .rst_n(rst_n), .open_row(open_row),
            .cas_fall(cas_fall[i]), .we_n(we_n), .oe_n(oe_n),
            .release_all(release_all), .wr_en(wr_en[i]),
            .drive(drive[i]), .dq_oe(dq_oe[i])
        );
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (ras_fall) begin
                    if (&cas_n)      nxt = ST_ROR;
                    else if (|drive) nxt = ST_HID;
                    else             nxt = ST_CBR;
                end
            end
            ST_ROR: begin
                if (ras_n)          nxt = ST_IDLE;
                else if (|cas_fall) nxt = ST_RW;
            end
            ST_RW, ST_CBR, ST_HID: begin
                if (ras_n) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            row_q <= '0;
            col_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && ras_fall)
                row_q <= (&cas_n) ? addr : cnt;
            if (open_row && cas_hi_prev)
                col_q <= addr;
        end
    end

    always_comb begin
        mode_o   = state;
        row_act  = (state != ST_IDLE);
        row_sel  = row_q;
        col_addr = col_q;
    end

    // R2
    ror_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROR) |-> (dq_oe == '0));
    // R8
    cbr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CBR) |-> (dq_oe == '0 && wr_en == '0));
    // R9
    hid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HID) |-> (|drive));
    // R11
    ras_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && ras_n) |=> (state == ST_IDLE));
endmodule

// File: tb/dram_mode_dec_tb.sv
module dram_mode_dec_tb;
    localparam int ROW_W  = 12;
    localparam int N_LANE = 4;
    localparam int ROWS   = 1 << ROW_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ras_n = 1'b1;
    logic [N_LANE-1:0] cas_n = '1;
    logic              we_n = 1'b1;
    logic              oe_n = 1'b1;
    logic [ROW_W-1:0]  addr = '0;
    logic [2:0]        mode_o;
    logic              row_act;
    logic [ROW_W-1:0]  row_sel, col_addr;
    logic [N_LANE-1:0] wr_en, dq_oe;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;

    always #2.5 clk = ~clk;

    dram_mode_dec #(.ROW_W(ROW_W), .N_LANE(N_LANE)) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .mode_o(mode_o),
        .row_act(row_act), .row_sel(row_sel), .col_addr(col_addr),
        .wr_en(wr_en), .dq_oe(dq_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [N_LANE-1:0] rd_oe(input logic [N_LANE-1:0] lanes, input logic oe);
        return oe ? '0 : lanes;
    endfunction

    function automatic logic [N_LANE-1:0] pick_lanes();
        logic [N_LANE-1:0] l;
        l = N_LANE'($urandom);
        if (l == '0) l = 1;
        return l;
    endfunction

    task automatic ror(input logic [ROW_W-1:0] row);
        ras_n = 1'b0; addr = row; step();
        chk("R2 mode", mode_o, 2);
        chk("R2 row", row_sel, row);
        chk("R2 act", row_act, 1);
        chk("R2 hiz", dq_oe, 0);
        ras_n = 1'b1; step();
        chk("R11 idle", mode_o, 0);
    endtask

    task automatic cbr(input logic [N_LANE-1:0] lanes);
        cas_n = ~lanes; step();
        ras_n = 1'b0; oe_n = 1'b0; we_n = 1'($urandom); step();
        chk("R8 mode", mode_o, 3);
        chk("R8 row", row_sel, exp_cnt);
        chk("R8 hiz", dq_oe, 0);
        chk("R8 nowr", wr_en, 0);
        ras_n = 1'b1; step();
        chk("R11 idle", mode_o, 0);
        exp_cnt = (exp_cnt + 1) % ROWS;
        cas_n = '1; we_n = 1'b1; oe_n = 1'b1; step();
    endtask

    task automatic access(input logic [ROW_W-1:0] row, input logic [ROW_W-1:0] col,
                          input logic [ROW_W-1:0] col2, input logic wr,
                          input logic [N_LANE-1:0] lanes, input logic oe);
        logic [N_LANE-1:0] dexp;
        dexp = wr ? '0 : rd_oe(lanes, oe);
        ras_n = 1'b0; addr = row; step();
        chk("R2 mode", mode_o, 2);
        addr = col; we_n = ~wr; oe_n = oe; cas_n = ~lanes; step();
        chk("R3 mode", mode_o, 1);
        chk("R3 row", row_sel, row);
        chk("R4 col", col_addr, col);
        chk("R5 wr", wr_en, wr ? lanes : '0);
        chk("R6 oe", dq_oe, dexp);
        addr = ROW_W'($urandom); step();
        chk("R4 hold", col_addr, col);
        chk("R5 pulse", wr_en, 0);
        cas_n = '1; step();
        chk("R6 edo", dq_oe, dexp);
        addr = col2; cas_n = ~lanes; step();
        chk("R4 page", col_addr, col2);
        chk("R5 page", wr_en, wr ? lanes : '0);
        cas_n = '1; step();
        ras_n = 1'b1; step();
        chk("R11 idle", mode_o, 0);
        chk("R7 rel", dq_oe, 0);
        we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic hidden(input logic [ROW_W-1:0] row, input logic [N_LANE-1:0] lanes);
        ras_n = 1'b0; addr = row; step();
        addr = ROW_W'($urandom); cas_n = ~lanes; we_n = 1'b1; oe_n = 1'b0; step();
        chk("R6 rd", dq_oe, lanes);
        ras_n = 1'b1; step();
        chk("R6 keep", dq_oe, lanes);
        chk("R11 idle", mode_o, 0);
        ras_n = 1'b0; we_n = 1'($urandom); step();
        chk("R9 mode", mode_o, 4);
        chk("R9 row", row_sel, exp_cnt);
        chk("R9 drive", dq_oe, lanes);
        oe_n = 1'b1; step();
        chk("R6 oe off", dq_oe, 0);
        oe_n = 1'b0; step();
        chk("R9 back", dq_oe, lanes);
        ras_n = 1'b1; step();
        chk("R11 idle", mode_o, 0);
        exp_cnt = (exp_cnt + 1) % ROWS;
        cas_n = '1; step();
        chk("R7 rel", dq_oe, 0);
        we_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        chk("R1 mode", mode_o, 0);
        rst_n = 1'b1; step();
        chk("R1 mode", mode_o, 0);
        chk("R1 act", row_act, 0);
        chk("R1 wr", wr_en, 0);
        chk("R1 oe", dq_oe, 0);
        cbr(4'b0001);
        chk("R1 first row", exp_cnt, 1);
        ror(12'hABC);
        access(12'h123, 12'h045, 12'h046, 1'b0, 4'b1111, 1'b0);
        access(12'h321, 12'h7FF, 12'h000, 1'b1, 4'b0101, 1'b0);
        access(12'h111, 12'h010, 12'h020, 1'b0, 4'b0011, 1'b1);
        hidden(12'h222, 4'b1000);
        cbr(4'b1111);
        for (int k = 0; k < 300; k++) begin
            case ($urandom % 5)
                0: ror(ROW_W'($urandom));
                1: access(ROW_W'($urandom), ROW_W'($urandom), ROW_W'($urandom),
                          1'b0, pick_lanes(), 1'($urandom));
                2: access(ROW_W'($urandom), ROW_W'($urandom), ROW_W'($urandom),
                          1'b1, pick_lanes(), 1'($urandom));
                3: cbr(pick_lanes());
                default: hidden(ROW_W'($urandom), pick_lanes());
            endcase
        end
        // R10: sweep the full row space so the counter wraps
        for (int k = 0; k < ROWS; k++) cbr(4'b0010);
        cbr(4'b0100);
        chk("R10 wrap", row_sel, (exp_cnt + ROWS - 1) % ROWS);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule